// File: doc/BRIEF.md
# Highway and Farm-Road Junction Light Controller

This block sequences the lights at a junction where a busy highway crosses a lightly used farm road. The highway keeps right of way by default. A farm-road car sensor asks for a handover. Two 5-bit interval inputs set the phase lengths. The long interval sets how long each green is held. The short interval sets how long each yellow lasts. Both are run-time values, and the controller samples the relevant one at the moment a phase starts.

Once a farm car is waiting and the highway green has run its long interval, the controller runs a fixed cycle:

1. Highway yellow.
2. An all-red clearance cycle.
3. Farm green.
4. Farm yellow.
5. A second all-red clearance cycle.
6. Highway green again.

The farm green is cut short as soon as the sensor reports the road empty.

A single down-counter times every phase. All pins are plain control and status signals sampled or driven every clock. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure to manage.

Top module: `tlc_junction_ctrl`

## Requirements
- R1: Each light output is 2 bits encoded as GREEN = 2'd0, YELLOW = 2'd1, RED = 2'd2; the value 2'd3 never appears.
- R2: While the synchronous active-high reset is sampled high, the highway light shows GREEN, the farm light shows RED and the interval counter is cleared, so a car present on the first cycle after reset starts highway yellow at the next edge.
- R3: With the car sensor low, the highway stays GREEN and the farm light stays RED for any number of cycles.
- R4: Phase order is fixed: highway yellow, all red, farm green, farm yellow, all red, highway green.
- R5: After returning to highway green with long value L sampled on entry, the highway shows GREEN for at least L+1 cycles before yellow, even with a car present.
- R6: Each yellow phase lasts exactly S+1 cycles, where S is the short value sampled on the edge that starts it.
- R7: With the car present throughout, farm green lasts exactly L+1 cycles, L being the long value sampled on the edge that starts it.
- R8: Farm green ends at the first edge where the car sensor is sampled low, moving to farm yellow, even before its interval expires.
- R9: Exactly one all-red cycle separates each yellow from the opposing green.
- R10: The two lights are never both non-RED in the same cycle.
- R11: Changing the interval inputs during a running phase has no effect on that phase's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| car_present | input | 1 | Farm-road car sensor, high when a car waits or passes |
| long_ivl | input | 5 | Green interval in cycles, sampled when a green starts |
| short_ivl | input | 5 | Yellow interval in cycles, sampled when a yellow starts |
| hwy_light | output | 2 | Highway light: 0 green, 1 yellow, 2 red |
| farm_light | output | 2 | Farm light: 0 green, 1 yellow, 2 red |

## Verification
The assertions assume the sensor and both interval inputs are settled, known values at every rising edge once reset is released. They also assume reset is held for at least one edge before the first checked cycle. The stimulus changes the inputs only on falling clock edges and keeps reset high from time zero for several cycles. Interval values, including zero, are always driven explicitly and never left floating, so the counter-reload and phase-successor properties only ever see defined inputs.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  typedef enum logic [1:0] {
    LIGHT_GREEN  = 2'd0,
    LIGHT_YELLOW = 2'd1,
    LIGHT_RED    = 2'd2
  } light_t;

  typedef enum logic [2:0] {
    PH_HWY_GO,
    PH_HWY_WARN,
    PH_CLEAR_TO_FARM,
    PH_FARM_GO,
    PH_FARM_WARN,
    PH_CLEAR_TO_HWY
  } phase_t;
endpackage

// File: rtl/tlc_interval_timer.sv
module tlc_interval_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R6
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> cnt_q == $past(load_val_i));

  // R7
  count_down_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && cnt_q != '0) |=> cnt_q == W'($past(cnt_q) - 1'b1));
endmodule

// File: rtl/tlc_phase_fsm.sv
module tlc_phase_fsm
  import tlc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   car_i,
  input  logic   timer_zero_i,
  output phase_t phase_o,
  output logic   load_o,
  output logic   load_long_o
);
  phase_t phase_q, phase_d;

  always_comb begin
    phase_d     = phase_q;
    load_o      = 1'b0;
    load_long_o = 1'b0;
    case (phase_q)
      PH_HWY_GO: if (timer_zero_i && car_i) begin
        phase_d = PH_HWY_WARN;
        load_o  = 1'b1;
      end
      PH_HWY_WARN: if (timer_zero_i) phase_d = PH_CLEAR_TO_FARM;
      PH_CLEAR_TO_FARM: begin
        phase_d     = PH_FARM_GO;
        load_o      = 1'b1;
        load_long_o = 1'b1;
      end
      PH_FARM_GO: if (timer_zero_i || !car_i) begin
        phase_d = PH_FARM_WARN;
        load_o  = 1'b1;
      end
      PH_FARM_WARN: if (timer_zero_i) phase_d = PH_CLEAR_TO_HWY;
      PH_CLEAR_TO_HWY: begin
        phase_d     = PH_HWY_GO;
        load_o      = 1'b1;
        load_long_o = 1'b1;
      end
      default: phase_d = PH_HWY_GO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_HWY_GO;
    else     phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_HWY_GO && !car_i) |=> phase_q == PH_HWY_GO);

  // R9
  clear_farm_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_CLEAR_TO_FARM) |=> phase_q == PH_FARM_GO);

  // R9
  clear_hwy_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_CLEAR_TO_HWY) |=> phase_q == PH_HWY_GO);

  // R4
  hwy_warn_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_HWY_WARN) |=> (phase_q == PH_HWY_WARN || phase_q == PH_CLEAR_TO_FARM));

  // R4
  farm_warn_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_FARM_WARN) |=> (phase_q == PH_FARM_WARN || phase_q == PH_CLEAR_TO_HWY));

  // R8
  early_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_FARM_GO && !car_i) |=> phase_q == PH_FARM_WARN);
endmodule

// File: rtl/tlc_light_decode.sv
module tlc_light_decode
  import tlc_pkg::*;
(
  input  phase_t phase_i,
  output light_t hwy_o,
  output light_t farm_o
);
  always_comb begin
    hwy_o  = LIGHT_RED;
    farm_o = LIGHT_RED;
    case (phase_i)
      PH_HWY_GO:    hwy_o  = LIGHT_GREEN;
      PH_HWY_WARN:  hwy_o  = LIGHT_YELLOW;
      PH_FARM_GO:   farm_o = LIGHT_GREEN;
      PH_FARM_WARN: farm_o = LIGHT_YELLOW;
      default: ;
    endcase
  end
endmodule

// File: rtl/tlc_junction_ctrl.sv
module tlc_junction_ctrl #(
  parameter int IVL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             car_present,
  input  logic [IVL_W-1:0] long_ivl,
  input  logic [IVL_W-1:0] short_ivl,
  output logic [1:0]       hwy_light,
  output logic [1:0]       farm_light
);
  import tlc_pkg::*;

  phase_t           phase;
  logic             load, load_long, timer_zero;
  logic [IVL_W-1:0] load_val;
  light_t           hwy_l, farm_l;

  assign load_val = load_long ? long_ivl : short_ivl;

  tlc_phase_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .car_i        (car_present),
    .timer_zero_i (timer_zero),
    .phase_o      (phase),
    .load_o       (load),
    .load_long_o  (load_long)
  );

  tlc_interval_timer #(.W(IVL_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .load_val_i (load_val),
    .zero_o     (timer_zero)
  );

  tlc_light_decode u_decode (
    .phase_i (phase),
    .hwy_o   (hwy_l),
    .farm_o  (farm_l)
  );

  assign hwy_light  = hwy_l;
  assign farm_light = farm_l;

  // R10
  one_way_chk: assert property (@(posedge clk) disable iff (rst)
    !(hwy_light != 2'd2 && farm_light != 2'd2));

  // R1
  legal_code_chk: assert property (@(posedge clk) disable iff (rst)
    hwy_light != 2'd3 && farm_light != 2'd3);
endmodule

// File: tb/tb_tlc_junction_ctrl.sv
`timescale 1ns/1ps
module tb_tlc_junction_ctrl;
  localparam logic [1:0] G = 2'd0, Y = 2'd1, R = 2'd2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       car = 1'b0;
  logic [4:0] lng = 5'd5, sht = 5'd2;
  logic [1:0] hwy, farm;
  int nvec = 0, nbad = 0;

  always #10 clk = ~clk;

  tlc_junction_ctrl dut (
    .clk(clk), .rst(rst), .car_present(car), .long_ivl(lng), .short_ivl(sht),
    .hwy_light(hwy), .farm_light(farm)
  );

  // {car, expected hwy, expected farm}; long=5, short=2 throughout
  localparam logic [4:0] VEC [0:22] = '{
    {1'b0, G, R}, {1'b0, G, R}, {1'b1, Y, R}, {1'b1, Y, R}, {1'b1, Y, R},
    {1'b1, R, R}, {1'b1, R, G}, {1'b1, R, G}, {1'b1, R, G}, {1'b1, R, G},
    {1'b1, R, G}, {1'b1, R, G}, {1'b1, R, Y}, {1'b1, R, Y}, {1'b1, R, Y},
    {1'b1, R, R}, {1'b1, G, R}, {1'b1, G, R}, {1'b1, G, R}, {1'b1, G, R},
    {1'b1, G, R}, {1'b1, G, R}, {1'b1, Y, R}
  };

  task automatic check(input logic [1:0] eh, input logic [1:0] ef, input string tag);
    nvec++;
    if (hwy !== eh || farm !== ef) begin
      nbad++;
      $display("FAIL %s: hwy=%0d farm=%0d expected hwy=%0d farm=%0d", tag, hwy, farm, eh, ef);
    end
    nvec++;
    if (hwy !== R && farm !== R) begin
      nbad++;
      $display("FAIL R10: hwy=%0d farm=%0d expected at least one RED (2)", hwy, farm);
    end
  endtask

  task automatic step(input logic c, input logic [4:0] l, input logic [4:0] s,
                      input logic [1:0] eh, input logic [1:0] ef, input string tag);
    @(negedge clk);
    car = c; lng = l; sht = s;
    @(posedge clk);
    #1;
    check(eh, ef, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; car = 1'b0;
    @(posedge clk);
    #1;
    check(G, R, "R2 reset state");
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    nbad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(G, R, "R2/R1 reset state");
    @(negedge clk);
    rst = 1'b0;

    // R4 R5 R6 R7 R9: full handover and back with long=5 short=2
    for (int i = 0; i < 23; i++)
      step(VEC[i][4], 5'd5, 5'd2, VEC[i][3:2], VEC[i][1:0], "R4/R5/R6/R7/R9 table");

    // R2: reset mid-yellow, counter cleared so car starts yellow at once
    do_reset();
    step(1'b1, 5'd5, 5'd2, Y, R, "R2 cleared timer");

    // R6 R11: yellow loaded with 3, short changed to 0 mid-phase
    do_reset();
    step(1'b1, 5'd5, 5'd3, Y, R, "R6 yellow start");
    for (int k = 0; k < 3; k++) step(1'b1, 5'd5, 5'd0, Y, R, "R11 yellow held");
    step(1'b1, 5'd5, 5'd0, R, R, "R9 all red");
    step(1'b1, 5'd2, 5'd1, R, G, "R4 farm green");

    // R8: sensor drops during farm green with time left
    step(1'b0, 5'd2, 5'd1, R, Y, "R8 early exit");
    step(1'b0, 5'd2, 5'd1, R, Y, "R6 farm yellow");
    step(1'b0, 5'd2, 5'd1, R, R, "R9 all red");
    step(1'b0, 5'd0, 5'd1, G, R, "R4 highway green");

    // R3: no car, highway holds
    for (int k = 0; k < 40; k++) step(1'b0, 5'd0, 5'd1, G, R, "R3 idle hold");
    step(1'b1, 5'd0, 5'd1, Y, R, "R5 zero long interval");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule